// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block accepts one decimal digit as a 4-bit binary-coded-decimal value and keeps it in a clocked storage register. A load-enable input controls whether the register takes the new value or keeps the one it has. The stored value is decoded into drive levels for the seven segments of a numeric readout. Values above nine are not digits, so the decoder turns every segment off for them.

Three further controls shape the output. A blanking input darkens the digit. A ripple-blank pair lets several digit blocks be chained so that zeroes with no significance are suppressed: a block whose stored value is zero and whose ripple input is high goes dark and raises its ripple output toward the next digit. A phase input inverts all seven outputs as the final step. With a square wave on phase and on the display backplane, this drives a liquid-crystal readout. A fixed level on phase suits common-anode or common-cathode LEDs.

The storage register is the only state in the block. Segment and ripple outputs follow the stored value and the control inputs without a clock delay.

Top module: `seg7_latch_decoder`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the stored value to 0. After reset, with blank, phase and ripple input low, `seg_out` reads 7'h3F and `ripple_out` is low.
- R2: At a clock edge where `load_en` is high, the stored value takes the value of `digit_in`. While `load_en` is low, the stored value is unchanged whatever `digit_in` does.
- R3: `digit_in` carries a BCD value with bit 0 weighted 1 and bit 3 weighted 8. `seg_out` bit 0..6 drive segments a..g: a top, b upper right, c lower right, d bottom, e lower left, f upper left, g middle. With phase low, the lit segments are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all seven, 9 abcdfg.
- R4: Stored values 10 to 15 turn off all seven segments.
- R5: While `blank_in` is high, all segments are off, whatever value is stored.
- R6: While `phase_in` is high, each of the seven outputs is the inverse of its phase-low level.
- R7: Inversion by phase is applied after all blanking. A blanked digit with `phase_in` high therefore shows `seg_out` = 7'h7F.
- R8: When `ripple_in` is high and the stored value is 0, all segments are off and `ripple_out` is high. In every other case `ripple_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | High: store `digit_in` at the clock edge. Low: hold the stored value |
| digit_in | input | 4 | BCD digit to store |
| blank_in | input | 1 | Darkens all segments |
| phase_in | input | 1 | Inverts all segment outputs |
| ripple_in | input | 1 | Zero-suppression request from the neighbouring digit |
| seg_out | output | 7 | Segment drive, bit 0 = a through bit 6 = g |
| ripple_out | output | 1 | Zero-suppression request passed on to the next digit |

## Verification
The hardest case to reach is ripple suppression acting on the stored value while `digit_in` shows something else. The bench loads a zero, closes the load enable, moves `digit_in` to non-zero values and then raises `ripple_in`. In that state only the stored value can explain a dark digit with `ripple_out` high. It also runs the opposite case: a non-zero value is held while `digit_in` reads zero. These cases, together with blanking of every code under both phases, are mixed into a long run of pseudo-random inputs. A behavioural model checks the outputs on every clock.

// File: rtl/seg7_pkg.sv
// Package for the segment decoder: widths, the bit order of the
// segment vector, and the digit-to-pattern function.
// Assumes bit 0 of a pattern drives segment a and bit 6 drives segment g.
package seg7_pkg;
    localparam int CODE_W    = 4;
    localparam int SEG_N     = 7;
    localparam int MAX_DIGIT = 9;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_N-1:0]  seg_t;

    // Returns the active-high pattern for a stored value; non-digits give zero.
    function automatic seg_t digit_pattern(input code_t v);
        seg_t p;
        case (v)
            code_t'(0): p = 7'b0111111;
            code_t'(1): p = 7'b0000110;
            code_t'(2): p = 7'b1011011;
            code_t'(3): p = 7'b1001111;
            code_t'(4): p = 7'b1100110;
            code_t'(5): p = 7'b1101101;
            code_t'(6): p = 7'b1111101;
            code_t'(7): p = 7'b0000111;
            code_t'(8): p = 7'b1111111;
            code_t'(9): p = 7'b1101111;
            default:    p = '0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/seg7_code_store.sv
// Storage register for the digit value.
// Takes the input on a clock edge while load is high and keeps its value
// otherwise. Synchronous active-low reset clears it to zero.
module seg7_code_store #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Register: clear, load, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R2
    AST_TAKE_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d))); // R2
endmodule

// File: rtl/seg7_digit_decoder.sv
// Converts a stored value to the active-high segment pattern.
// Values above MAX_DIGIT produce an all-off pattern. Purely combinational.
module seg7_digit_decoder
    import seg7_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t code,
    output seg_t  raw,
    output logic  is_zero
);
    // Look up the pattern and flag the zero value.
    always_comb begin
        raw     = digit_pattern(code);
        is_zero = (code == '0);
    end

    AST_ILLEGAL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code) > MAX_DIGIT) |-> (raw == '0)); // R4
endmodule

// File: rtl/seg7_output_stage.sv
// Applies blanking, ripple suppression and then phase inversion to the
// decoded pattern. Assumes raw is active high and already dark for
// non-digit values.
module seg7_output_stage
    import seg7_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  seg_t raw,
    input  logic is_zero,
    input  logic blank,
    input  logic phase,
    input  logic rip_in,
    output seg_t seg,
    output logic rip_out
);
    logic suppress;
    seg_t lit;

    // Darken on blank or ripple suppression, then invert by phase.
    always_comb begin
        suppress = rip_in & is_zero;
        lit      = (blank | suppress) ? '0 : raw;
        seg      = lit ^ {SEG_N{phase}};
        rip_out  = suppress;
    end

    AST_BLANK_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (seg == {SEG_N{phase}})); // R7
    AST_RIPPLE_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rip_out |-> (rip_in && is_zero)); // R8
    AST_RIPPLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        rip_out |-> (seg == {SEG_N{phase}})); // R8
endmodule

// File: rtl/seg7_latch_decoder.sv
// Top level: one BCD digit register feeding a seven-segment decoder with
// blanking, ripple zero suppression and phase inversion.
// Assumes all control inputs are synchronous to clk.
module seg7_latch_decoder
    import seg7_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CODE_W-1:0] digit_in,
    input  logic              blank_in,
    input  logic              phase_in,
    input  logic              ripple_in,
    output logic [SEG_N-1:0]  seg_out,
    output logic              ripple_out
);
    code_t stored;
    seg_t  raw;
    logic  zero;

    seg7_code_store #(.W(CODE_W)) u_store (
        .clk (clk), .rst_n (rst_n), .load (load_en), .d (digit_in), .q (stored)
    );

    seg7_digit_decoder u_dec (
        .clk (clk), .rst_n (rst_n), .code (stored), .raw (raw), .is_zero (zero)
    );

    seg7_output_stage u_out (
        .clk (clk), .rst_n (rst_n), .raw (raw), .is_zero (zero),
        .blank (blank_in), .phase (phase_in), .rip_in (ripple_in),
        .seg (seg_out), .rip_out (ripple_out)
    );

    AST_PHASE_FLIPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(stored) && $stable(blank_in) && $stable(ripple_in) && $changed(phase_in))
        |-> (seg_out == ~$past(seg_out))); // R6
endmodule

// File: tb/seg7_latch_decoder_bench.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module seg7_latch_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] digit_in = 4'd0;
    logic       blank_in = 1'b0;
    logic       phase_in = 1'b0;
    logic       ripple_in = 1'b0;
    logic [6:0] seg_out;
    logic       ripple_out;

    int checks = 0;
    int errors = 0;
    int model_code = 0;
    string tag = "";
    bit finished = 0;

    always #10 clk = ~clk;

    seg7_latch_decoder u_seg7_latch_decoder (
        .clk (clk), .rst_n (rst_n), .load_en (load_en), .digit_in (digit_in),
        .blank_in (blank_in), .phase_in (phase_in), .ripple_in (ripple_in),
        .seg_out (seg_out), .ripple_out (ripple_out)
    );

    // Reference: stored value per R1/R2.
    always @(posedge clk) begin
        if (!rst_n) model_code <= 0;
        else if (load_en) model_code <= int'(digit_in);
    end

    // Lit segments by letter, per R3.
    function automatic logic [6:0] letters_to_mask(input string s);
        logic [6:0] m = '0;
        for (int i = 0; i < s.len(); i++) m[s[i] - "a"] = 1'b1;
        return m;
    endfunction

    function automatic logic [6:0] expected_seg(input int code);
        string lit_by_digit [10] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg",
                                     "acdfg", "acdefg", "abc", "abcdefg", "abcdfg"};
        logic [6:0] m;
        if (code > 9 || blank_in || (ripple_in && code == 0)) m = '0;
        else m = letters_to_mask(lit_by_digit[code]);
        return phase_in ? ~m : m;
    endfunction

    task automatic compare();
        logic [6:0] es;
        logic       er;
        string      why;
        es = expected_seg(model_code);
        er = ripple_in && (model_code == 0);
        if (ripple_in && model_code == 0) why = "R8";
        else if (blank_in) why = phase_in ? "R7" : "R5";
        else if (model_code > 9) why = "R4";
        else if (phase_in) why = "R6";
        else why = "R3";
        checks++;
        if (seg_out !== es) begin
            errors++;
            $display("FAIL %s/%s seg_out actual=%h expected=%h (code %0d)", tag, why, seg_out, es, model_code);
        end
        checks++;
        if (ripple_out !== er) begin
            errors++;
            $display("FAIL %s/R8 ripple_out actual=%b expected=%b", tag, ripple_out, er);
        end
    endtask

    // One clock: check settled outputs, then apply the next inputs.
    task automatic step(input bit ld, input int d, input bit bl, input bit ph, input bit ri);
        @(negedge clk);
        compare();
        load_en = ld; digit_in = 4'(d); blank_in = bl; phase_in = ph; ripple_in = ri;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        step(0, 5, 0, 0, 0);
        step(0, 5, 0, 0, 0);
        tag = "R3";
        for (int ph = 0; ph < 2; ph++)
            for (int d = 0; d < 16; d++) begin
                step(1, d, 0, ph[0], 0);
                step(0, 15 - d, 0, ph[0], 0);
            end
        tag = "R5";
        for (int d = 0; d < 16; d++) begin
            step(1, d, 1, 0, 0);
            step(0, d, 1, 1, 0);
        end
        tag = "R2";
        step(1, 0, 0, 0, 0);
        step(0, 7, 0, 0, 0);
        step(0, 3, 0, 0, 1);
        step(0, 9, 0, 1, 1);
        step(1, 6, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        tag = "R8";
        step(1, 0, 0, 0, 1);
        step(0, 4, 0, 1, 1);
        step(0, 4, 1, 1, 1);
        step(0, 4, 0, 0, 0);
        tag = "RND";
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom);
            step(r[0], (r[1] ? 0 : (r >> 4) & 15), r[2] & r[3], r[5], r[6]);
            if (n == 1500) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
            end
        end
        @(negedge clk);
        compare();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule